// File: doc/BRIEF.md
# Floating-Point Trap Commit Controller

This block sits at the retirement point of an in-order core. Each cycle it sees at most one retiring instruction: its own address, the address of the instruction after it, a raw result of up to 64 bits, a destination register, the floating-point status bits from the FPU, and indications for a precise fault, a system call, a return-from-trap and a level-sensitive interrupt request. It decides whether the result goes to the register file, whether control transfers to the trap vector, and which address is saved as the resume address.

A floating-point exception is handled as a post-commit event. The faulting instruction still writes its result. On overflow or underflow that result is first forced to a correctly signed infinity or zero. The saved resume address is that of the next instruction, so returning from the handler does not run the FP instruction again. A precise fault is handled differently: the result is discarded and the faulting instruction's own address is saved. The block also holds the status register (interrupt enable and FP-trap enable), its saved copy, and a sticky accumulator of FP flags.

Top module: `fpx_commit_ctrl`

## Requirements
- R1: When a retiring FP instruction raises any flag while the FP-trap enable is set (and there is no precise fault), the result is written to the register file in that same cycle. On the next cycle a trap is taken, and the saved resume address equals the retiring next-instruction address.
- R2: When the overflow flag is set, the written value is infinity with the sign bit of the raw result. In double format this is sign, exponent 0x7FF and zero fraction. In single format it is sign, exponent 0xFF and zero fraction in bits 31:0.
- R3: When the underflow flag is set, the written value is zero with the sign bit of the raw result. This is bit 63 for double format and bit 31 for single format. All other bits are zero.
- R4: When the FP-trap enable is clear, raised flags cause no trap. The result is still written, with the R2/R3 saturation applied. A single-format result always has bits 63:32 written as zero.
- R5: A precise fault blocks write-back. On the next cycle it takes a trap and saves the faulting instruction's own address.
- R6: A system call saves the next-instruction address. An interrupt request is taken only at the retirement of a valid instruction, only while the interrupt enable is set, and never on a return-from-trap. The interrupted instruction still writes its result, and the next-instruction address is saved.
- R7: On the cycle after any trap is decided, the block pulses a redirect to TRAP_VECTOR. At the same time the status register is copied into the saved status, and both enable bits are cleared.
- R8: A retiring return-from-trap pulses a redirect to the saved resume address on the next cycle and restores the status register from the saved status.
- R9: Flag bit positions are [4] overflow, [3] underflow, [2] invalid, [1] divide-by-zero and [0] inexact. Flags from every non-faulting retiring FP instruction accumulate in a sticky register. A clear request empties it, but flags arriving in the same cycle as a clear are kept.
- R10: When an interrupt request and an FP exception fall on the same retirement, only the FP trap is taken. The interrupt is taken after the return-from-trap has restored the interrupt enable.
- R11: After reset, the status register, saved status, resume address and sticky flags are all zero, and no redirect or write is asserted.
- R12: A software status write loads bit 0 as interrupt enable and bit 1 as FP-trap enable. If a trap entry or return falls in the same cycle, that event takes precedence over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | ADDR_W | Address of the retiring instruction |
| ret_npc | input | ADDR_W | Address of the next instruction |
| ret_is_fp | input | 1 | Retiring instruction is an FP operation |
| ret_is_dbl | input | 1 | FP result is double format |
| ret_wen | input | 1 | Instruction has a destination register |
| ret_rd | input | REG_AW | Destination register index |
| ret_result | input | 64 | Raw result |
| ret_fflags | input | 5 | FP status bits, layout per R9 |
| ret_fault | input | 1 | Precise fault on this instruction |
| ret_syscall | input | 1 | Instruction is a system call |
| ret_rfe | input | 1 | Instruction is a return-from-trap |
| irq_req | input | 1 | Level interrupt request (timer or external) |
| sr_wr | input | 1 | Software status write strobe |
| sr_wdata | input | 2 | Status write data: bit 1 FP-trap enable, bit 0 interrupt enable |
| flag_clr | input | 1 | Clear the sticky flags |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | REG_AW | Register file write index |
| rf_wdata | output | 64 | Register file write data |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | ADDR_W | Redirect target |
| epcr | output | ADDR_W | Saved resume address |
| sr_ie | output | 1 | Interrupt enable |
| sr_fpee | output | 1 | FP-trap enable |
| esr | output | 2 | Saved status, layout as sr_wdata |
| fflags_sticky | output | 5 | Accumulated FP flags |

## Verification
The interesting collision is an interrupt request arriving on the same retirement as an FP instruction that raises an enabled exception. The bench holds the interrupt line high, with both enables set, while an overflowing FP instruction retires. It expects exactly one trap, with the FP result already saturated and written, the next-instruction address saved, and both enables cleared. A further retirement with the line still high must not redirect. After the return-from-trap restores the enables, the next retirement must take the interrupt and save its own next-instruction address.

// File: rtl/fpx_commit_pkg.sv
package fpx_commit_pkg;

    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
    localparam int DP_W      = 1 + DP_EXP_W + DP_FRAC_W;
    localparam int NFLAGS    = 5;

    typedef enum logic [2:0] {
        CAUSE_NONE,
        CAUSE_FAULT,
        CAUSE_FPE,
        CAUSE_SYSCALL,
        CAUSE_IRQ
    } cause_e;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic inv;
        logic dz;
        logic inx;
    } fflags_t;

    typedef struct packed {
        logic fpee;
        logic ie;
    } sr_t;

    function automatic logic [DP_W-1:0] sp_special(input logic sign, input logic inf);
        logic [SP_W-1:0] v;
        v = {sign, {SP_EXP_W{inf}}, {SP_FRAC_W{1'b0}}};
        return {{(DP_W-SP_W){1'b0}}, v};
    endfunction

    function automatic logic [DP_W-1:0] dp_special(input logic sign, input logic inf);
        return {sign, {DP_EXP_W{inf}}, {DP_FRAC_W{1'b0}}};
    endfunction

endpackage

// File: rtl/fpx_saturate.sv
module fpx_saturate
    import fpx_commit_pkg::*;
(
    input  logic            is_fp,
    input  logic            is_dbl,
    input  fflags_t         flags,
    input  logic [DP_W-1:0] raw,
    output logic [DP_W-1:0] fixed
);
    logic sp_sign;
    logic dp_sign;

    always_comb begin
        sp_sign = raw[SP_W-1];
        dp_sign = raw[DP_W-1];
        if (!is_fp) begin
            fixed = raw;
        end else if (is_dbl) begin
            if (flags.ovf)      fixed = dp_special(dp_sign, 1'b1);
            else if (flags.unf) fixed = dp_special(dp_sign, 1'b0);
            else                fixed = raw;
        end else begin
            if (flags.ovf)      fixed = sp_special(sp_sign, 1'b1);
            else if (flags.unf) fixed = sp_special(sp_sign, 1'b0);
            else                fixed = {{(DP_W-SP_W){1'b0}}, raw[SP_W-1:0]};
        end
    end
endmodule

// File: rtl/fpx_trap_arbiter.sv
module fpx_trap_arbiter
    import fpx_commit_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              valid,
    input  logic              is_fp,
    input  fflags_t           flags,
    input  logic              fault,
    input  logic              syscall,
    input  logic              rfe,
    input  logic              irq,
    input  sr_t               sr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] npc,
    output cause_e            cause,
    output logic              take,
    output logic              do_rfe,
    output logic [ADDR_W-1:0] epc_value
);
    logic fp_exc;
    logic irq_ok;

    always_comb begin
        fp_exc = valid && is_fp && (|flags) && sr.fpee;
        irq_ok = valid && irq && sr.ie && !rfe;
        if (valid && fault)   cause = CAUSE_FAULT;
        else if (fp_exc)      cause = CAUSE_FPE;
        else if (valid && syscall) cause = CAUSE_SYSCALL;
        else if (irq_ok)      cause = CAUSE_IRQ;
        else                  cause = CAUSE_NONE;
        take      = (cause != CAUSE_NONE);
        do_rfe    = valid && rfe && !fault;
        epc_value = (cause == CAUSE_FAULT) ? pc : npc;
    end
endmodule

// File: rtl/fpx_ctrl_regs.sv
module fpx_ctrl_regs
    import fpx_commit_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] TRAP_VECTOR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [ADDR_W-1:0] epc_value,
    input  logic              do_rfe,
    input  logic              sr_wr,
    input  sr_t               sr_wdata,
    input  logic              flag_upd,
    input  fflags_t           flag_in,
    input  logic              flag_clr,
    output sr_t               sr,
    output sr_t               esr,
    output logic [ADDR_W-1:0] epcr,
    output fflags_t           sticky,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc
);
    fflags_t sticky_base;
    fflags_t sticky_new;

    always_comb begin
        sticky_base = flag_clr ? '0 : sticky;
        sticky_new  = flag_upd ? (sticky_base | flag_in) : sticky_base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr             <= '0;
            esr            <= '0;
            epcr           <= '0;
            sticky         <= '0;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            sticky         <= sticky_new;
            redirect_valid <= take || do_rfe;
            if (take) begin
                esr         <= sr;
                sr          <= '0;
                epcr        <= epc_value;
                redirect_pc <= TRAP_VECTOR;
            end else if (do_rfe) begin
                sr          <= esr;
                redirect_pc <= epcr;
            end else if (sr_wr) begin
                sr          <= sr_wdata;
            end
        end
    end

    AST_ENTRY_MASK: assert property (@(posedge clk) disable iff (rst)
        take |=> (!sr.ie && !sr.fpee && redirect_valid && redirect_pc == TRAP_VECTOR)); // R7

    AST_RFE_RESTORE: assert property (@(posedge clk) disable iff (rst)
        (do_rfe && !take) |=> (sr == $past(esr) && redirect_valid)); // R8

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!flag_clr) |=> ((sticky & $past(sticky)) == $past(sticky))); // R9
endmodule

// File: rtl/fpx_commit_ctrl.sv
module fpx_commit_ctrl
    import fpx_commit_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                REG_AW      = 5,
    parameter logic [ADDR_W-1:0] TRAP_VECTOR = 32'h0000_0D00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ret_valid,
    input  logic [ADDR_W-1:0] ret_pc,
    input  logic [ADDR_W-1:0] ret_npc,
    input  logic              ret_is_fp,
    input  logic              ret_is_dbl,
    input  logic              ret_wen,
    input  logic [REG_AW-1:0] ret_rd,
    input  logic [63:0]       ret_result,
    input  logic [4:0]        ret_fflags,
    input  logic              ret_fault,
    input  logic              ret_syscall,
    input  logic              ret_rfe,
    input  logic              irq_req,
    input  logic              sr_wr,
    input  logic [1:0]        sr_wdata,
    input  logic              flag_clr,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_waddr,
    output logic [63:0]       rf_wdata,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic [ADDR_W-1:0] epcr,
    output logic              sr_ie,
    output logic              sr_fpee,
    output logic [1:0]        esr,
    output logic [4:0]        fflags_sticky
);
    fflags_t           flags;
    sr_t               sr_q;
    sr_t               esr_q;
    fflags_t           sticky_q;
    cause_e            cause;
    logic              take;
    logic              do_rfe;
    logic [ADDR_W-1:0] epc_value;
    logic [DP_W-1:0]   fixed;
    logic              flag_upd;

    assign flags    = fflags_t'(ret_fflags);
    assign flag_upd = ret_valid && ret_is_fp && !ret_fault;

    fpx_saturate u_sat (
        .is_fp  (ret_is_fp),
        .is_dbl (ret_is_dbl),
        .flags  (flags),
        .raw    (ret_result),
        .fixed  (fixed)
    );

    fpx_trap_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .valid     (ret_valid),
        .is_fp     (ret_is_fp),
        .flags     (flags),
        .fault     (ret_fault),
        .syscall   (ret_syscall),
        .rfe       (ret_rfe),
        .irq       (irq_req),
        .sr        (sr_q),
        .pc        (ret_pc),
        .npc       (ret_npc),
        .cause     (cause),
        .take      (take),
        .do_rfe    (do_rfe),
        .epc_value (epc_value)
    );

    fpx_ctrl_regs #(.ADDR_W(ADDR_W), .TRAP_VECTOR(TRAP_VECTOR)) u_regs (
        .clk            (clk),
        .rst            (rst),
        .take           (take),
        .epc_value      (epc_value),
        .do_rfe         (do_rfe),
        .sr_wr          (sr_wr),
        .sr_wdata       (sr_t'(sr_wdata)),
        .flag_upd       (flag_upd),
        .flag_in        (flags),
        .flag_clr       (flag_clr),
        .sr             (sr_q),
        .esr            (esr_q),
        .epcr           (epcr),
        .sticky         (sticky_q),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    always_comb begin
        rf_we    = ret_valid && ret_wen && !ret_fault;
        rf_waddr = ret_rd;
        rf_wdata = fixed;
    end

    assign sr_ie         = sr_q.ie;
    assign sr_fpee       = sr_q.fpee;
    assign esr           = esr_q;
    assign fflags_sticky = sticky_q;

    AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && ret_fault) |-> !rf_we); // R5

    AST_FAULT_EPCR: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && ret_fault) |=> (epcr == $past(ret_pc) && redirect_valid)); // R5

    AST_FPE_EPCR: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !ret_fault && ret_is_fp && (|ret_fflags) && sr_fpee)
            |=> (redirect_valid && epcr == $past(ret_npc))); // R1

    AST_FPE_WB: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !ret_fault && ret_is_fp && ret_wen && (|ret_fflags)) |-> rf_we); // R1

    AST_NO_FPE_TRAP: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && ret_is_fp && !sr_fpee && !sr_ie && !ret_fault && !ret_syscall && !ret_rfe)
            |=> !redirect_valid); // R4
endmodule

// File: tb/tb_fpx_commit_ctrl.sv
module tb_fpx_commit_ctrl;
    localparam logic [31:0] VEC = 32'h0000_0D00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ret_valid = 0, ret_is_fp = 0, ret_is_dbl = 0, ret_wen = 0;
    logic [31:0] ret_pc = 0, ret_npc = 0;
    logic [4:0]  ret_rd = 0;
    logic [63:0] ret_result = 0;
    logic [4:0]  ret_fflags = 0;
    logic        ret_fault = 0, ret_syscall = 0, ret_rfe = 0, irq_req = 0;
    logic        sr_wr = 0, flag_clr = 0;
    logic [1:0]  sr_wdata = 0;
    logic        rf_we, redirect_valid, sr_ie, sr_fpee;
    logic [4:0]  rf_waddr, fflags_sticky;
    logic [63:0] rf_wdata;
    logic [31:0] redirect_pc, epcr;
    logic [1:0]  esr;

    int total = 0;
    int bad   = 0;
    logic        c_we;
    logic [63:0] c_wdata;

    always #4 clk = ~clk;

    fpx_commit_ctrl #(.TRAP_VECTOR(VEC)) dut (
        .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_npc(ret_npc),
        .ret_is_fp(ret_is_fp), .ret_is_dbl(ret_is_dbl), .ret_wen(ret_wen), .ret_rd(ret_rd),
        .ret_result(ret_result), .ret_fflags(ret_fflags), .ret_fault(ret_fault),
        .ret_syscall(ret_syscall), .ret_rfe(ret_rfe), .irq_req(irq_req), .sr_wr(sr_wr),
        .sr_wdata(sr_wdata), .flag_clr(flag_clr), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .epcr(epcr), .sr_ie(sr_ie), .sr_fpee(sr_fpee), .esr(esr), .fflags_sticky(fflags_sticky)
    );

    typedef struct packed {
        logic        dbl;
        logic        fpee;
        logic [4:0]  flags;
        logic [63:0] raw;
        logic [63:0] expd;
        logic        trap;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TABLE [NV] = '{
        '{1'b0, 1'b1, 5'h00, 64'hDEAD_BEEF_3F80_0000, 64'h0000_0000_3F80_0000, 1'b0},
        '{1'b0, 1'b1, 5'h11, 64'h0000_0000_7F7F_FFFF, 64'h0000_0000_7F80_0000, 1'b1},
        '{1'b0, 1'b1, 5'h10, 64'h0000_0000_FF00_0000, 64'h0000_0000_FF80_0000, 1'b1},
        '{1'b1, 1'b1, 5'h09, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000, 1'b1},
        '{1'b1, 1'b1, 5'h10, 64'h7FEF_FFFF_FFFF_FFFF, 64'h7FF0_0000_0000_0000, 1'b1},
        '{1'b0, 1'b0, 5'h08, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0000, 1'b0},
        '{1'b0, 1'b1, 5'h01, 64'h0000_0000_4049_0FDB, 64'h0000_0000_4049_0FDB, 1'b1}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_sr(input logic [1:0] v);
        @(negedge clk);
        sr_wr = 1; sr_wdata = v;
        @(posedge clk); #1;
        sr_wr = 0;
    endtask

    task automatic commit(input logic fp, input logic dbl, input logic wen, input logic [4:0] fl,
                          input logic [63:0] raw, input logic flt, input logic sys, input logic rfe,
                          input logic [31:0] pc);
        @(negedge clk);
        ret_valid = 1; ret_is_fp = fp; ret_is_dbl = dbl; ret_wen = wen; ret_rd = 5'd7;
        ret_fflags = fl; ret_result = raw; ret_fault = flt; ret_syscall = sys; ret_rfe = rfe;
        ret_pc = pc; ret_npc = pc + 32'd4;
        #1;
        c_we = rf_we; c_wdata = rf_wdata;
        @(posedge clk); #1;
        ret_valid = 0; ret_is_fp = 0; ret_fault = 0; ret_syscall = 0; ret_rfe = 0;
        ret_fflags = 0; ret_wen = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R11 reset state
        chk(epcr == 0 && esr == 0 && !sr_ie && !sr_fpee, "R11 regs", {epcr, 30'b0, esr}, 0);
        chk(fflags_sticky == 0 && !redirect_valid && !rf_we, "R11 outs",
            {58'b0, fflags_sticky, redirect_valid}, 0);

        // R12 software status write
        set_sr(2'b10);
        chk(sr_fpee && !sr_ie, "R12 sr write", {62'b0, sr_fpee, sr_ie}, 64'h2);

        // table walk: R1 R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            set_sr({TABLE[i].fpee, 1'b0});
            commit(1'b1, TABLE[i].dbl, 1'b1, TABLE[i].flags, TABLE[i].raw, 0, 0, 0, 32'h100 + 32'(i*16));
            chk(c_we == 1'b1, "R1/R4 write-back", {63'b0, c_we}, 1);
            chk(c_wdata == TABLE[i].expd, "R2/R3/R4 result value", c_wdata, TABLE[i].expd);
            chk(redirect_valid == TABLE[i].trap, "R1/R4 trap decision",
                {63'b0, redirect_valid}, {63'b0, TABLE[i].trap});
            if (TABLE[i].trap) begin
                chk(epcr == 32'h104 + 32'(i*16), "R1 epcr next addr", {32'b0, epcr},
                    {32'b0, 32'h104 + 32'(i*16)});
                chk(redirect_pc == VEC && !sr_fpee && esr == 2'b10, "R7 entry",
                    {redirect_pc, 30'b0, esr}, {VEC, 32'h2});
            end
        end
        chk(fflags_sticky == 5'h19, "R9 sticky accumulate", {59'b0, fflags_sticky}, 64'h19);

        // R9 clear, and same-cycle set wins
        @(negedge clk); flag_clr = 1; @(posedge clk); #1; flag_clr = 0;
        chk(fflags_sticky == 0, "R9 clear", {59'b0, fflags_sticky}, 0);
        @(negedge clk);
        flag_clr = 1; ret_valid = 1; ret_is_fp = 1; ret_fflags = 5'h02; ret_result = 0;
        @(posedge clk); #1;
        flag_clr = 0; ret_valid = 0; ret_is_fp = 0; ret_fflags = 0;
        chk(fflags_sticky == 5'h02, "R9 clear vs set", {59'b0, fflags_sticky}, 64'h02);

        // R5 precise fault
        set_sr(2'b11);
        commit(1'b0, 0, 1'b1, 5'h00, 64'h55, 1'b1, 0, 0, 32'h400);
        chk(c_we == 0, "R5 no write", {63'b0, c_we}, 0);
        chk(redirect_valid && epcr == 32'h400, "R5 epcr own addr", {32'b0, epcr}, 64'h400);

        // R6 syscall
        set_sr(2'b00);
        commit(1'b0, 0, 1'b0, 5'h00, 64'h0, 0, 1'b1, 0, 32'h500);
        chk(redirect_valid && epcr == 32'h504, "R6 syscall epcr", {32'b0, epcr}, 64'h504);

        // R6 interrupt ignored while disabled
        irq_req = 1;
        commit(1'b0, 0, 1'b1, 5'h00, 64'h9, 0, 0, 0, 32'h580);
        chk(!redirect_valid, "R6 irq masked", {63'b0, redirect_valid}, 0);

        // R10 interrupt plus FP exception in one cycle
        set_sr(2'b11);
        commit(1'b1, 0, 1'b1, 5'h10, 64'h0000_0000_7F7F_0000, 0, 0, 0, 32'h600);
        chk(c_we && c_wdata == 64'h7F80_0000, "R10 fp result written", c_wdata, 64'h7F80_0000);
        chk(redirect_valid && epcr == 32'h604 && esr == 2'b11 && !sr_ie, "R10 single trap",
            {epcr, 30'b0, esr}, {32'h604, 32'h3});
        commit(1'b0, 0, 1'b1, 5'h00, 64'h1, 0, 0, 0, 32'hD00);
        chk(!redirect_valid, "R10 irq held during handler", {63'b0, redirect_valid}, 0);

        // R8 return from trap
        commit(1'b0, 0, 1'b0, 5'h00, 64'h0, 0, 0, 1'b1, 32'hD04);
        chk(redirect_valid && redirect_pc == 32'h604, "R8 resume addr",
            {32'b0, redirect_pc}, 64'h604);
        chk(sr_ie && sr_fpee, "R8 sr restored", {62'b0, sr_fpee, sr_ie}, 64'h3);

        // R10 / R6 pending interrupt now taken, result still written
        commit(1'b0, 0, 1'b1, 5'h00, 64'h77, 0, 0, 0, 32'h604);
        chk(c_we && c_wdata == 64'h77, "R6 irq instr writes", c_wdata, 64'h77);
        chk(redirect_valid && epcr == 32'h608 && redirect_pc == VEC, "R10 irq after return",
            {32'b0, epcr}, 64'h608);
        irq_req = 0;

        // R12 trap entry beats same-cycle software write
        set_sr(2'b10);
        @(negedge clk);
        sr_wr = 1; sr_wdata = 2'b11;
        ret_valid = 1; ret_is_fp = 1; ret_fflags = 5'h04; ret_pc = 32'h700; ret_npc = 32'h704;
        @(posedge clk); #1;
        sr_wr = 0; ret_valid = 0; ret_is_fp = 0; ret_fflags = 0;
        chk(!sr_ie && !sr_fpee && esr == 2'b10, "R12 trap over write",
            {60'b0, sr_fpee, sr_ie, esr}, 64'h2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule